// File: doc/BRIEF.md
# Programmable CRC-32 Checksum Engine

This block is a register-mapped checksum accelerator on a simple 32-bit bus with byte write strobes. Software sets a 32-bit generator polynomial and a starting value. It then issues a load command that copies the starting value into the running checksum. After that it streams message data into the data register. A write with all four strobes set folds a whole word into the checksum. A write with exactly one strobe set folds in only the byte on that lane. Each write is absorbed in the clock cycle that carries it, so the engine never stalls the bus.

Bit reversal can be applied to the data before it enters the checksum: per byte, per half-word or across the whole word. A separate option returns the checksum bit-reversed on reads. With these options, bit-reflected standards such as CRC-32 and CRC-32C are reached from a most-significant-bit-first core. A long message can be split across sessions: software reads the partial checksum, restores it as the starting value later, and issues the load command again.

Top module: `crc_mmio_engine`

## Requirements
- R1: After reset the checksum reads 0xFFFFFFFF, the start-value register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7 and the control register reads 0.
- R2: Registers are decoded on byte address bits [4:2]: checksum/data at 0x00, control at 0x08, start value at 0x10, polynomial at 0x14. Start value and polynomial are updated per byte lane where the strobe is set. A read of any other address returns 0. When no read is in progress (select low or write high), bus_rdata is 0.
- R3: A control write with strobe bit 0 set and data bit 0 equal to 1 loads the start value into the checksum by the next cycle. The same write latches control bits [7:5]. Control bit 0 always reads back as 0.
- R4: A data write with strobe 1111 folds 32 bits into the checksum, most significant bit first. For each bit d: f = c[31] XOR d, then c = (c << 1) XOR (f ? poly : 0). The update is done in one cycle, so back-to-back writes on consecutive cycles are all absorbed.
- R5: A data write with exactly one strobe bit k set folds the 8 bits wdata[8k+7:8k] into the checksum by the same rule.
- R6: A data write whose strobe is 0000 or has two or three bits set leaves the checksum unchanged.
- R7: Control bits [6:5] choose input reversal for word writes. 00 means none, 01 reverses the bits within each byte, 10 within each 16-bit half, and 11 across all 32 bits. For byte writes, any nonzero value reverses the bits of the byte.
- R8: With control bit 7 set, reads of the data register return the checksum with all 32 bits reversed. The stored checksum itself is not changed.
- R9: Byte and word writes may be mixed freely. Rewriting the control register with bit 0 clear does not change the checksum.
- R10: Writing the bit-reversal of a partial result (read back with bit 7 set) into the start value, then loading it with control 0xE1, continues the computation exactly as if it had not been interrupted.
- R11: With polynomial 0x04C11DB7, start value 0xFFFFFFFF and control 0xE1, the ASCII string "123456789" yields 0xCBF43926 after inverting the read value. With polynomial 0x1EDC6F41 and the same setup, it yields 0xE3069283.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wstrb | input | DATA_W/8 (4) | Byte lane write strobes |
| bus_rdata | output | DATA_W (32) | Read data, combinational from address during a read |

## Verification
The bench uses the default parameters: a 32-bit data path, a 5-bit address and the reset values 0xFFFFFFFF and 0x04C11DB7. Because the default polynomial is the CRC-32 generator, the CRC-32 check string runs straight after reset. CRC-32C is reached only by reprogramming the polynomial. The 32-bit width gives four byte lanes and all four reversal codes. It also makes the half-word reversal mode a distinct pattern rather than a degenerate one.

// File: rtl/crc_mmio_pkg.sv
package crc_mmio_pkg;

  typedef enum logic [1:0] {
    REV_NONE = 2'b00,
    REV_BYTE = 2'b01,
    REV_HALF = 2'b10,
    REV_WORD = 2'b11
  } rev_mode_e;

  typedef struct packed {
    logic      rev_out;
    rev_mode_e rev_in;
  } crc_ctrl_t;

  // word offsets of the register slots (byte offset / 4)
  localparam int unsigned SLOT_DATA = 0;
  localparam int unsigned SLOT_CTRL = 2;
  localparam int unsigned SLOT_INIT = 4;
  localparam int unsigned SLOT_POLY = 5;

  // control field positions
  localparam int unsigned CTL_LOAD_BIT = 0;
  localparam int unsigned CTL_RIN_LSB  = 5;
  localparam int unsigned CTL_ROUT_BIT = 7;

  function automatic logic [7:0] flip8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

endpackage

// File: rtl/crc_in_swizzle.sv
module crc_in_swizzle
  import crc_mmio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  rev_mode_e           mode,
  output logic [DATA_W-1:0]   word_o,
  output logic [7:0]          byte_o,
  output logic                is_word,
  output logic                is_byte
);
  localparam int NBYTES = DATA_W / 8;
  localparam int HALF_W = (DATA_W >= 16) ? 16 : DATA_W;

  logic [DATA_W-1:0] per_byte, per_half, whole;
  logic [7:0]        lane_byte;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign per_byte[i] = wdata[(i/8)*8 + 7 - (i%8)];
    assign per_half[i] = wdata[(i/HALF_W)*HALF_W + HALF_W - 1 - (i%HALF_W)];
    assign whole[i]    = wdata[DATA_W-1-i];
  end

  always_comb begin
    unique case (mode)
      REV_BYTE: word_o = per_byte;
      REV_HALF: word_o = per_half;
      REV_WORD: word_o = whole;
      default:  word_o = wdata;
    endcase
  end

  always_comb begin
    lane_byte = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (wstrb[b]) lane_byte = wdata[b*8 +: 8];
    end
  end

  assign byte_o  = (mode != REV_NONE) ? flip8(lane_byte) : lane_byte;
  assign is_word = &wstrb;
  assign is_byte = $onehot(wstrb);

endmodule

// File: rtl/crc_xor_net.sv
module crc_xor_net #(
  parameter int CRC_W = 32,
  parameter int DW    = 32
) (
  input  logic [CRC_W-1:0] crc_i,
  input  logic [CRC_W-1:0] poly_i,
  input  logic [DW-1:0]    data_i,
  output logic [CRC_W-1:0] crc_o
);
  // unrolled MSB-first division: one stage per data bit
  function automatic logic [CRC_W-1:0] fold(
    input logic [CRC_W-1:0] c_in,
    input logic [CRC_W-1:0] p,
    input logic [DW-1:0]    d
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c  = c_in;
    fb = 1'b0;
    for (int k = DW - 1; k >= 0; k--) begin
      fb = c[CRC_W-1] ^ d[k];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? p : '0);
    end
    return c;
  endfunction

  assign crc_o = fold(crc_i, poly_i, data_i);

endmodule

// File: rtl/crc_regfile.sv
module crc_regfile
  import crc_mmio_pkg::*;
#(
  parameter int               DATA_W   = 32,
  parameter int               ADDR_W   = 5,
  parameter logic [DATA_W-1:0] INIT_RST = '1,
  parameter logic [DATA_W-1:0] POLY_RST = 32'h04C11DB7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_wstrb,
  output logic [DATA_W-1:0]   init_q,
  output logic [DATA_W-1:0]   poly_q,
  output crc_ctrl_t           ctrl_q,
  output logic                load_init,
  output logic                data_wr,
  output logic                data_hit,
  output logic                ctrl_hit,
  output logic [DATA_W-1:0]   reg_rdata
);
  localparam int NBYTES = DATA_W / 8;
  localparam int SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slot;
  logic              init_hit, poly_hit, wr;
  logic [1:0]        addr_unused;

  assign slot        = bus_addr[ADDR_W-1:2];
  assign addr_unused = bus_addr[1:0];
  assign wr          = bus_sel & bus_we;

  assign data_hit = (slot == SLOT_W'(SLOT_DATA));
  assign ctrl_hit = (slot == SLOT_W'(SLOT_CTRL));
  assign init_hit = (slot == SLOT_W'(SLOT_INIT));
  assign poly_hit = (slot == SLOT_W'(SLOT_POLY));

  assign data_wr   = wr & data_hit;
  assign load_init = wr & ctrl_hit & bus_wstrb[0] & bus_wdata[CTL_LOAD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= INIT_RST;
      poly_q <= POLY_RST;
      ctrl_q <= '0;
    end else if (wr) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (init_hit && bus_wstrb[b]) init_q[b*8 +: 8] <= bus_wdata[b*8 +: 8];
        if (poly_hit && bus_wstrb[b]) poly_q[b*8 +: 8] <= bus_wdata[b*8 +: 8];
      end
      if (ctrl_hit && bus_wstrb[0]) begin
        ctrl_q.rev_out <= bus_wdata[CTL_ROUT_BIT];
        ctrl_q.rev_in  <= rev_mode_e'(bus_wdata[CTL_RIN_LSB +: 2]);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (ctrl_hit) begin
      reg_rdata[CTL_ROUT_BIT]       = ctrl_q.rev_out;
      reg_rdata[CTL_RIN_LSB +: 2]   = ctrl_q.rev_in;
    end else if (init_hit) begin
      reg_rdata = init_q;
    end else if (poly_hit) begin
      reg_rdata = poly_q;
    end
  end

endmodule

// File: rtl/crc_mmio_engine.sv
module crc_mmio_engine
  import crc_mmio_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 5,
  parameter logic [DATA_W-1:0] INIT_RST = '1,
  parameter logic [DATA_W-1:0] POLY_RST = 32'h04C11DB7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_wstrb,
  output logic [DATA_W-1:0]   bus_rdata
);
  logic [DATA_W-1:0] init_q, poly_q, reg_rdata;
  crc_ctrl_t         ctrl_q;
  logic              load_init, data_wr, data_hit, ctrl_hit;

  logic [DATA_W-1:0] word_sw, nxt_word, nxt_byte, crc_q, crc_flip;
  logic [7:0]        byte_sw;
  logic              is_word, is_byte;
  logic              absorb_word, absorb_byte, rd;

  crc_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INIT_RST(INIT_RST), .POLY_RST(POLY_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .init_q(init_q), .poly_q(poly_q), .ctrl_q(ctrl_q),
    .load_init(load_init), .data_wr(data_wr),
    .data_hit(data_hit), .ctrl_hit(ctrl_hit), .reg_rdata(reg_rdata)
  );

  crc_in_swizzle #(.DATA_W(DATA_W)) u_swz (
    .wdata(bus_wdata), .wstrb(bus_wstrb), .mode(ctrl_q.rev_in),
    .word_o(word_sw), .byte_o(byte_sw), .is_word(is_word), .is_byte(is_byte)
  );

  crc_xor_net #(.CRC_W(DATA_W), .DW(DATA_W)) u_net_word (
    .crc_i(crc_q), .poly_i(poly_q), .data_i(word_sw), .crc_o(nxt_word)
  );

  crc_xor_net #(.CRC_W(DATA_W), .DW(8)) u_net_byte (
    .crc_i(crc_q), .poly_i(poly_q), .data_i(byte_sw), .crc_o(nxt_byte)
  );

  assign absorb_word = data_wr & is_word;
  assign absorb_byte = data_wr & is_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           crc_q <= INIT_RST;
    else if (load_init)   crc_q <= init_q;
    else if (absorb_word) crc_q <= nxt_word;
    else if (absorb_byte) crc_q <= nxt_byte;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    assign crc_flip[i] = crc_q[DATA_W-1-i];
  end

  assign rd = bus_sel & ~bus_we;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (data_hit) bus_rdata = ctrl_q.rev_out ? crc_flip : crc_q;
      else          bus_rdata = reg_rdata;
    end
  end

endmodule

// File: rtl/crc_mmio_engine_chk.sv
module crc_mmio_engine_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic              ctrl_hit,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] crc_q,
  input logic [DATA_W-1:0] init_q,
  input logic              load_init,
  input logic              data_wr,
  input logic              absorb_word,
  input logic              absorb_byte
);
  p_load_takes_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_init |=> crc_q == $past(init_q));

  p_load_bit_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && ctrl_hit) |-> bus_rdata[0] == 1'b0);

  p_single_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_init, absorb_word, absorb_byte}));

  p_bad_strobe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !absorb_word && !absorb_byte) |=> $stable(crc_q));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_init || data_wr) |=> $stable(crc_q));

  p_quiet_rdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |-> bus_rdata == '0);
endmodule

bind crc_mmio_engine crc_mmio_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .ctrl_hit(ctrl_hit), .bus_rdata(bus_rdata), .crc_q(crc_q), .init_q(init_q),
  .load_init(load_init), .data_wr(data_wr),
  .absorb_word(absorb_word), .absorb_byte(absorb_byte)
);

// File: tb/crc_mmio_engine_tb.sv
`timescale 1ns/1ps
module crc_mmio_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_crc = 32'hFFFFFFFF, m_init = 32'hFFFFFFFF, m_poly = 32'h04C11DB7;
  logic [1:0]  m_rin = 2'b00;
  logic        m_rout = 1'b0;

  always #2.5 clk = ~clk;

  crc_mmio_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] rg(input logic [31:0] x, input int g);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[(i/g)*g + g - 1 - (i%g)];
    return r;
  endfunction

  function automatic logic [31:0] m_absorb(input logic [31:0] c, input logic [31:0] p,
                                           input logic [31:0] d, input int n);
    logic [31:0] r;
    logic        b;
    r = c;
    for (int k = n - 1; k >= 0; k--) begin
      b = r[31] ^ d[k];
      r = r << 1;
      if (b) r = r ^ p;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] a);
    case (a[4:2])
      3'd0: return m_rout ? rg(m_crc, 32) : m_crc;
      3'd2: return {24'b0, m_rout, m_rin, 5'b0};
      3'd4: return m_init;
      3'd5: return m_poly;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] w;
    logic [31:0] lb;
    case (a[4:2])
      3'd0: begin
        if (s == 4'hF) begin
          w = (m_rin == 2'd1) ? rg(d, 8) : (m_rin == 2'd2) ? rg(d, 16) :
              (m_rin == 2'd3) ? rg(d, 32) : d;
          m_crc = m_absorb(m_crc, m_poly, w, 32);
        end else if (s == 4'h1 || s == 4'h2 || s == 4'h4 || s == 4'h8) begin
          lb = 32'h0;
          for (int k = 0; k < 4; k++) if (s[k]) lb[7:0] = d[k*8 +: 8];
          if (m_rin != 2'd0) lb = rg(lb, 8);
          m_crc = m_absorb(m_crc, m_poly, lb, 8);
        end
      end
      3'd2: if (s[0]) begin
        if (d[0]) m_crc = m_init;
        m_rin  = d[6:5];
        m_rout = d[7];
      end
      3'd4: for (int k = 0; k < 4; k++) if (s[k]) m_init[k*8 +: 8] = d[k*8 +: 8];
      3'd5: for (int k = 0; k < 4; k++) if (s[k]) m_poly[k*8 +: 8] = d[k*8 +: 8];
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wstrb = '0;
    model_write(a, d, s);
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a);
    logic [31:0] v;
    bus_rd(a, v);
    check(req, v, exp_rd(a));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R4 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, part, snap;
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset contents
    bus_rd(5'h00, v); check("R1 checksum", v, 32'hFFFFFFFF);
    bus_rd(5'h08, v); check("R1 control", v, 32'h0);
    bus_rd(5'h10, v); check("R1 start value", v, 32'hFFFFFFFF);
    bus_rd(5'h14, v); check("R1 polynomial", v, 32'h04C11DB7);
    #1 check("R2 idle rdata", bus_rdata, 32'h0);
    rd_check("R2 unmapped", 5'h04);
    rd_check("R2 unmapped", 5'h18);

    // R2 per-lane strobes on start value
    bus_wr(5'h10, 32'h12345678, 4'b0011);
    bus_rd(5'h10, v); check("R2 partial strobe", v, 32'hFFFF5678);
    bus_wr(5'h10, 32'hFFFFFFFF, 4'hF);

    // R11 CRC-32 check string, R3 load and field latch
    bus_wr(5'h08, 32'h000000E1, 4'h1);
    bus_rd(5'h08, v); check("R3 load bit reads 0", v, 32'h000000E0);
    rd_check("R3 loaded", 5'h00);
    bus_wr(5'h00, 32'h34333231, 4'hF);
    bus_wr(5'h00, 32'h38373635, 4'hF);
    bus_wr(5'h00, 32'h00000039, 4'h1);
    bus_rd(5'h00, v); check("R11 crc32", ~v, 32'hCBF43926);
    check("R11 model", v, exp_rd(5'h00));

    // R10 chained sessions
    bus_wr(5'h08, 32'h000000E1, 4'h1);
    bus_wr(5'h00, 32'h34333231, 4'hF);
    bus_rd(5'h00, part);
    bus_wr(5'h08, 32'h000000E1, 4'h1);        // disturb with a fresh session
    bus_wr(5'h00, 32'hDEADBEEF, 4'hF);
    bus_wr(5'h10, rg(part, 32), 4'hF);
    bus_wr(5'h08, 32'h000000E1, 4'h1);
    bus_wr(5'h00, 32'h38373635, 4'hF);
    bus_wr(5'h00, 32'h00000035, 4'h4 & 4'h0 | 4'h1 & 4'h0 | 4'h0); // zero strobe, ignored
    bus_wr(5'h00, 32'h00390000, 4'h4);
    bus_rd(5'h00, v); check("R10 chained crc32", ~v, 32'hCBF43926);

    // R11 CRC-32C
    bus_wr(5'h14, 32'h1EDC6F41, 4'hF);
    bus_wr(5'h10, 32'hFFFFFFFF, 4'hF);
    bus_wr(5'h08, 32'h000000E1, 4'h1);
    bus_wr(5'h00, 32'h34333231, 4'hF);
    bus_wr(5'h00, 32'h38373635, 4'hF);
    bus_wr(5'h00, 32'h39000000, 4'h8);
    bus_rd(5'h00, v); check("R11 crc32c", ~v, 32'hE3069283);

    // R6 bad strobes leave checksum alone
    bus_rd(5'h00, snap);
    bus_wr(5'h00, 32'hA5A5A5A5, 4'b0011);
    bus_wr(5'h00, 32'h5A5A5A5A, 4'b0111);
    bus_wr(5'h00, 32'h12121212, 4'b0000);
    bus_rd(5'h00, v); check("R6 bad strobe", v, snap);

    // R8 output reversal does not touch state; R9 control rewrite keeps checksum
    bus_wr(5'h08, 32'h00000060, 4'h1);
    bus_rd(5'h00, v); check("R8 plain view", v, rg(snap, 32));
    check("R9 ctrl rewrite", v, exp_rd(5'h00));

    // R5 each lane, no reversal; R7 each mode
    bus_wr(5'h14, 32'h04C11DB7, 4'hF);
    for (int k = 0; k < 4; k++) begin
      bus_wr(5'h08, 32'h00000001, 4'h1);
      bus_wr(5'h00, 32'hC3A5_1E69 ^ (32'h11 << (8*k)), 4'h1 << k);
      rd_check("R5 byte lane", 5'h00);
    end
    for (int m = 0; m < 4; m++) begin
      bus_wr(5'h08, 32'h00000001 | (m << 5), 4'h1);
      bus_wr(5'h00, 32'h0F1E2D3C, 4'hF);
      rd_check("R7 word mode", 5'h00);
      bus_wr(5'h00, 32'h00C10000, 4'h4);
      rd_check("R7 byte mode", 5'h00);
    end

    // R4 back-to-back words on consecutive cycles
    bus_wr(5'h08, 32'h00000001, 4'h1);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h01234567; bus_wstrb = 4'hF;
    @(negedge clk);
    model_write(5'h00, 32'h01234567, 4'hF);
    bus_wdata = 32'h89ABCDEF;
    @(negedge clk);
    model_write(5'h00, 32'h89ABCDEF, 4'hF);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wstrb = '0;
    rd_check("R4 back-to-back", 5'h00);

    // random mix, R9 interleaving
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [3:0] s;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: bus_wr(5'h00, $urandom, 4'hF);
        3, 4: bus_wr(5'h00, $urandom, 4'h1 << $urandom_range(0, 3));
        5: begin s = 4'($urandom); bus_wr(5'h00, $urandom, s); end
        6: bus_wr(5'h08, $urandom & 32'hE1, 4'($urandom) | 4'h1);
        7: bus_wr(5'h10, $urandom, 4'($urandom));
        8: bus_wr(5'h14, $urandom, 4'($urandom));
        default: rd_check("R9 random read", 5'($urandom) & 5'h1C);
      endcase
      if (it % 5 == 0) rd_check("R9 random mix", 5'h00);
    end
    rd_check("R2 final start value", 5'h10);
    rd_check("R2 final polynomial", 5'h14);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule